// File: doc/BRIEF.md
# Selectable Event Counter with Outstanding-Time Histogram

This block counts one of many per-cycle performance events in a single 32-bit counter. A 6-bit selector picks the event. The selector can also switch the block into histogram mode. In that mode, sixteen 32-bit bins record how many cycles were spent at each level of outstanding read or write transactions. The block does not generate the events. Its inputs are strobes from the surrounding traffic logic:

- latency underruns
- internal-FIFO-full flags
- ready wait states
- channel handshakes with their burst-length fields
- a device-clock-on flag
- the current outstanding read and write counts

Software reaches the block through a small word-addressed register port with four locations:

| Address | Register | Access |
|---------|----------|--------|
| 0 | selector | read/write |
| 1 | event counter | read/write |
| 2 | bin index | read/write |
| 3 | bin data | read/write |

The bin data location reads or writes the bin named by the bin index. Register writes take effect at the next clock edge. Reads are combinational from the current register state.

Top module: `evt_hist_counter`

## Requirements
- R1: After reset the selector, the event counter, the bin index and all sixteen bins read 0.
- R2: With selector code 0, or any code not listed in R3 to R8 (for example 20, 33, 63), the event counter and every bin keep their values whatever the event inputs do.
- R3: Code 1 adds one to the counter on every clock cycle.
- R4: Codes 2 to 10 add one per cycle in which the matching input is high, as follows:
  - 2: read underrun
  - 3: write underrun
  - 4 to 8: `fifo_full_i` bits 0 to 4
  - 9: `r_wait_i`
  - 10: `b_wait_i`
- R5: Codes 11 to 15 add one per cycle in which `hs_i` bit 0, 1, 2, 3 or 4 is high, in that order.
- R6: Code 18 counts cycles with `dev_clk_on_i` high. Code 19 counts cycles with `dev_clk_on_i` low.
- R7: Code 32 counts cycles in which `hs_i` bit 3 is high and `ar_len_i` is 0. Code 48 counts cycles in which `hs_i` bit 4 is high and `aw_len_i` is 0.
- R8: With code 16 (or 17), each cycle adds one to the bin numbered `rd_outst_i` (or `wr_outst_i`), with counts above 15 clamped to 15. The event counter holds. In every other mode no bin changes except by a software write.
- R9: A write to address 2 sets the bin index. Address 3 reads and writes the indexed bin. A software write to a bin wins over a histogram increment to that same bin in the same cycle.
- R10: A write to address 1 loads the counter and wins over a same-cycle increment. Both the counter and the bins wrap from 2^32-1 to 0.
- R11: Selector writes keep the low 6 data bits and bin index writes keep the low 4 bits. A selector write is used for counting from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| under_rd_i | input | 1 | Read latency deadline missed this cycle |
| under_wr_i | input | 1 | Write latency deadline missed this cycle |
| fifo_full_i | input | 5 | Internal FIFO full flags, bits 0..4 = AR, AW, R, W, B |
| r_wait_i | input | 1 | Read data valid but not accepted |
| b_wait_i | input | 1 | Write response valid but not accepted |
| hs_i | input | 5 | Handshakes, bits 0..4 = R, W, B, AR, AW |
| ar_len_i | input | 8 | Burst length field of the read address handshake |
| aw_len_i | input | 8 | Burst length field of the write address handshake |
| dev_clk_on_i | input | 1 | Device clock enabled this cycle |
| rd_outst_i | input | 8 | Current outstanding read count |
| wr_outst_i | input | 8 | Current outstanding write count |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 selector, 1 counter, 2 bin index, 3 bin data |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |

## Verification
The hardest situation to reach is a software write to a bin while histogram mode is incrementing that very bin. It needs the bin index, the outstanding count and the write strobe to line up in one cycle, and the bin index can only be changed through the same port. The stimulus sets the index first, then holds the outstanding count on that bin and writes the data word in histogram mode. Separate directed cases do the following:

- drive counts far above 15 to hit the clamp
- preload the counter near 2^32 to see the wrap
- give address handshakes non-zero lengths to show the length qualifier rejects them

A seeded random phase then walks every code, including unsupported ones, with random strobes and occasional register writes.

// File: rtl/evh_pkg.sv
package evh_pkg;
    localparam int EV_OFF      = 0;
    localparam int EV_CYCLES   = 1;
    localparam int EV_UND_RD   = 2;
    localparam int EV_UND_WR   = 3;
    localparam int EV_FULL_LO  = 4;
    localparam int EV_FULL_HI  = 8;
    localparam int EV_RWAIT    = 9;
    localparam int EV_BWAIT    = 10;
    localparam int EV_HS_LO    = 11;
    localparam int EV_HS_HI    = 15;
    localparam int EV_HIST_RD  = 16;
    localparam int EV_HIST_WR  = 17;
    localparam int EV_CLK_ON   = 18;
    localparam int EV_CLK_OFF  = 19;
    localparam int EV_AR_LEN0  = 32;
    localparam int EV_AW_LEN0  = 48;

    localparam int HS_AR_BIT   = 3;
    localparam int HS_AW_BIT   = 4;

    typedef enum logic [1:0] {
        RA_SEL  = 2'd0,
        RA_CNT  = 2'd1,
        RA_BIN  = 2'd2,
        RA_DATA = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/evh_select.sv
module evh_select #(
    parameter int SEL_W = 6,
    parameter int OUT_W = 8,
    parameter int LEN_W = 8,
    parameter int NBINS = 16,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic             under_rd_i,
    input  logic             under_wr_i,
    input  logic [4:0]       fifo_full_i,
    input  logic             r_wait_i,
    input  logic             b_wait_i,
    input  logic [4:0]       hs_i,
    input  logic [LEN_W-1:0] ar_len_i,
    input  logic [LEN_W-1:0] aw_len_i,
    input  logic             dev_clk_on_i,
    input  logic [OUT_W-1:0] rd_outst_i,
    input  logic [OUT_W-1:0] wr_outst_i,
    output logic             cnt_inc_o,
    output logic             hist_inc_o,
    output logic [BIN_W-1:0] hist_idx_o
);
    import evh_pkg::*;

    localparam logic [OUT_W-1:0] TOP_BIN = OUT_W'(NBINS - 1);

    logic [OUT_W-1:0] level;
    int               code;

    always_comb begin
        code       = int'(sel_i);
        cnt_inc_o  = 1'b0;
        hist_inc_o = 1'b0;
        level      = rd_outst_i;
        if (code == EV_CYCLES) begin
            cnt_inc_o = 1'b1;
        end else if (code == EV_UND_RD) begin
            cnt_inc_o = under_rd_i;
        end else if (code == EV_UND_WR) begin
            cnt_inc_o = under_wr_i;
        end else if (code >= EV_FULL_LO && code <= EV_FULL_HI) begin
            cnt_inc_o = fifo_full_i[code - EV_FULL_LO];
        end else if (code == EV_RWAIT) begin
            cnt_inc_o = r_wait_i;
        end else if (code == EV_BWAIT) begin
            cnt_inc_o = b_wait_i;
        end else if (code >= EV_HS_LO && code <= EV_HS_HI) begin
            cnt_inc_o = hs_i[code - EV_HS_LO];
        end else if (code == EV_HIST_RD) begin
            hist_inc_o = 1'b1;
            level      = rd_outst_i;
        end else if (code == EV_HIST_WR) begin
            hist_inc_o = 1'b1;
            level      = wr_outst_i;
        end else if (code == EV_CLK_ON) begin
            cnt_inc_o = dev_clk_on_i;
        end else if (code == EV_CLK_OFF) begin
            cnt_inc_o = ~dev_clk_on_i;
        end else if (code == EV_AR_LEN0) begin
            cnt_inc_o = hs_i[HS_AR_BIT] && (ar_len_i == '0);
        end else if (code == EV_AW_LEN0) begin
            cnt_inc_o = hs_i[HS_AW_BIT] && (aw_len_i == '0);
        end
    end

    always_comb begin
        if (level > TOP_BIN) hist_idx_o = BIN_W'(NBINS - 1);
        else                 hist_idx_o = level[BIN_W-1:0];
    end
endmodule

// File: rtl/evh_hist_bank.sv
module evh_hist_bank #(
    parameter int NBINS = 16,
    parameter int CNT_W = 32,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic [BIN_W-1:0] inc_idx_i,
    input  logic             wr_i,
    input  logic [BIN_W-1:0] wr_idx_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [BIN_W-1:0] rd_idx_i,
    output logic [CNT_W-1:0] rd_data_o
);
    logic [CNT_W-1:0] bins_q [NBINS];
    logic [CNT_W-1:0] bins_d [NBINS];

    for (genvar b = 0; b < NBINS; b++) begin : g_bin
        always_comb begin
            bins_d[b] = bins_q[b];
            if (inc_i && inc_idx_i == BIN_W'(b)) bins_d[b] = bins_q[b] + CNT_W'(1);
            if (wr_i && wr_idx_i == BIN_W'(b))   bins_d[b] = wr_data_i;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) bins_q[b] <= '0;
            else        bins_q[b] <= bins_d[b];
        end
    end

    assign rd_data_o = bins_q[rd_idx_i];
endmodule

// File: rtl/evt_hist_counter.sv
module evt_hist_counter #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 6,
    parameter int NBINS = 16,
    parameter int OUT_W = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             under_rd_i,
    input  logic             under_wr_i,
    input  logic [4:0]       fifo_full_i,
    input  logic             r_wait_i,
    input  logic             b_wait_i,
    input  logic [4:0]       hs_i,
    input  logic [LEN_W-1:0] ar_len_i,
    input  logic [LEN_W-1:0] aw_len_i,
    input  logic             dev_clk_on_i,
    input  logic [OUT_W-1:0] rd_outst_i,
    input  logic [OUT_W-1:0] wr_outst_i,
    input  logic             reg_we_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o
);
    import evh_pkg::*;

    localparam int BIN_W = $clog2(NBINS);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
        logic [BIN_W-1:0] bin;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             cnt_inc, hist_inc;
    logic [BIN_W-1:0] hist_idx;
    logic             data_wr;
    logic [CNT_W-1:0] bin_data;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;

    assign sel_q   = ctl_q.sel;
    assign cnt_q   = ctl_q.cnt;
    assign data_wr = reg_we_i && (reg_addr_e'(reg_addr_i) == RA_DATA);

    evh_select #(
        .SEL_W(SEL_W), .OUT_W(OUT_W), .LEN_W(LEN_W), .NBINS(NBINS)
    ) u_select (
        .sel_i        (ctl_q.sel),
        .under_rd_i   (under_rd_i),
        .under_wr_i   (under_wr_i),
        .fifo_full_i  (fifo_full_i),
        .r_wait_i     (r_wait_i),
        .b_wait_i     (b_wait_i),
        .hs_i         (hs_i),
        .ar_len_i     (ar_len_i),
        .aw_len_i     (aw_len_i),
        .dev_clk_on_i (dev_clk_on_i),
        .rd_outst_i   (rd_outst_i),
        .wr_outst_i   (wr_outst_i),
        .cnt_inc_o    (cnt_inc),
        .hist_inc_o   (hist_inc),
        .hist_idx_o   (hist_idx)
    );

    evh_hist_bank #(
        .NBINS(NBINS), .CNT_W(CNT_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (hist_inc),
        .inc_idx_i (hist_idx),
        .wr_i      (data_wr),
        .wr_idx_i  (ctl_q.bin),
        .wr_data_i (reg_wdata_i),
        .rd_idx_i  (ctl_q.bin),
        .rd_data_o (bin_data)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (cnt_inc) ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
        if (reg_we_i) begin
            unique case (reg_addr_e'(reg_addr_i))
                RA_SEL:  ctl_d.sel = reg_wdata_i[SEL_W-1:0];
                RA_CNT:  ctl_d.cnt = reg_wdata_i;
                RA_BIN:  ctl_d.bin = reg_wdata_i[BIN_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        unique case (reg_addr_e'(reg_addr_i))
            RA_SEL:  reg_rdata_o = CNT_W'(ctl_q.sel);
            RA_CNT:  reg_rdata_o = ctl_q.cnt;
            RA_BIN:  reg_rdata_o = CNT_W'(ctl_q.bin);
            default: reg_rdata_o = bin_data;
        endcase
    end
endmodule

// File: rtl/evt_hist_counter_chk.sv
module evt_hist_counter_chk #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we_i,
    input logic [1:0]       reg_addr_i,
    input logic [CNT_W-1:0] reg_wdata_i,
    input logic [SEL_W-1:0] sel_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] bin_data
);
    function automatic logic counting(logic [SEL_W-1:0] s);
        int v;
        v = int'(s);
        return (v >= 1 && v <= 15) || v == 18 || v == 19 || v == 32 || v == 48;
    endfunction

    function automatic logic hist_mode(logic [SEL_W-1:0] s);
        return int'(s) == 16 || int'(s) == 17;
    endfunction

    logic sel_wr, cnt_wr, bin_wr, data_wr;
    assign sel_wr  = reg_we_i && reg_addr_i == 2'd0;
    assign cnt_wr  = reg_we_i && reg_addr_i == 2'd1;
    assign bin_wr  = reg_we_i && reg_addr_i == 2'd2;
    assign data_wr = reg_we_i && reg_addr_i == 2'd3;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !counting(sel_q)) |=> cnt_q == $past(cnt_q));

    assert_cycle_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && int'(sel_q) == 1) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    assert_bins_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_wr && !bin_wr && !hist_mode(sel_q)) |=> bin_data == $past(bin_data));

    assert_bin_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> bin_data == $past(reg_wdata_i));

    assert_cnt_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(reg_wdata_i));

    assert_sel_trunc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> sel_q == $past(reg_wdata_i[SEL_W-1:0]));
endmodule

bind evt_hist_counter evt_hist_counter_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .sel_q       (sel_q),
    .cnt_q       (cnt_q),
    .bin_data    (bin_data)
);

// File: tb/evt_hist_counter_tb.sv
module evt_hist_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        under_rd, under_wr, r_wait, b_wait, clk_on;
    logic [4:0]  full, hs;
    logic [7:0]  ar_len, aw_len, rd_out, wr_out;
    logic        we;
    logic [1:0]  addr;
    logic [31:0] wdata, rdata;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [5:0]  m_sel;
    logic [31:0] m_cnt;
    logic [3:0]  m_bin;
    logic [31:0] m_hist [16];

    always #5 clk = ~clk;

    evt_hist_counter u_dut (
        .clk(clk), .rst_n(rst_n), .under_rd_i(under_rd), .under_wr_i(under_wr),
        .fifo_full_i(full), .r_wait_i(r_wait), .b_wait_i(b_wait), .hs_i(hs),
        .ar_len_i(ar_len), .aw_len_i(aw_len), .dev_clk_on_i(clk_on),
        .rd_outst_i(rd_out), .wr_outst_i(wr_out), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
    );

    function automatic bit exp_hit(int s);
        if (s == 1) return 1;
        if (s == 2) return under_rd;
        if (s == 3) return under_wr;
        if (s >= 4 && s <= 8) return full[s-4];
        if (s == 9) return r_wait;
        if (s == 10) return b_wait;
        if (s >= 11 && s <= 15) return hs[s-11];
        if (s == 18) return clk_on;
        if (s == 19) return !clk_on;
        if (s == 32) return hs[3] && ar_len == 0;
        if (s == 48) return hs[4] && aw_len == 0;
        return 0;
    endfunction

    function automatic string req_of(int s);
        if (s == 1) return "R3";
        if (s >= 2 && s <= 10) return "R4";
        if (s >= 11 && s <= 15) return "R5";
        if (s == 16 || s == 17) return "R8";
        if (s == 18 || s == 19) return "R6";
        if (s == 32 || s == 48) return "R7";
        return "R2";
    endfunction

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic step();
        int lvl;
        if (!rst_n) begin
            m_sel = 0; m_cnt = 0; m_bin = 0;
            for (int i = 0; i < 16; i++) m_hist[i] = 0;
        end else begin
            if (int'(m_sel) == 16 || int'(m_sel) == 17) begin
                lvl = (int'(m_sel) == 16) ? int'(rd_out) : int'(wr_out);
                if (lvl > 15) lvl = 15;
                m_hist[lvl] = m_hist[lvl] + 1;
            end
            if (exp_hit(int'(m_sel))) m_cnt = m_cnt + 1;
            if (we) begin
                case (addr)
                    2'd0: m_sel = wdata[5:0];
                    2'd1: m_cnt = wdata;
                    2'd2: m_bin = wdata[3:0];
                    default: m_hist[m_bin] = wdata;
                endcase
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        we = 1; addr = a; wdata = d;
        step();
        we = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic quiet();
        under_rd = 0; under_wr = 0; r_wait = 0; b_wait = 0; clk_on = 0;
        full = 0; hs = 0; ar_len = 0; aw_len = 0; rd_out = 0; wr_out = 0;
    endtask

    task automatic rnd();
        under_rd = 1'($urandom); under_wr = 1'($urandom);
        r_wait = 1'($urandom); b_wait = 1'($urandom); clk_on = 1'($urandom);
        full = 5'($urandom); hs = 5'($urandom);
        ar_len = 8'($urandom_range(0, 3)); aw_len = 8'($urandom_range(0, 3));
        rd_out = 8'($urandom_range(0, 40)); wr_out = 8'($urandom_range(0, 40));
    endtask

    task automatic check_all(string req);
        logic [31:0] v;
        rd(2'd0, v); chk(req, "selector", v, 32'(m_sel));
        rd(2'd1, v); chk(req, "counter", v, m_cnt);
        for (int i = 0; i < 16; i++) begin
            wr(2'd2, 32'(i));
            rd(2'd3, v); chk(req, $sformatf("bin%0d", i), v, m_hist[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int codes [25] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,17,18,19,32,48,20,33,63};
        void'($urandom(32'd4711));
        quiet(); we = 0; addr = 0; wdata = 0;
        @(negedge clk); step(); step();
        rst_n = 1;
        // R1: reset state
        rd(2'd2, v); chk("R1", "bin index", v, 0);
        check_all("R1");

        // R3: cycles
        wr(2'd0, 1);
        for (int i = 0; i < 10; i++) step();
        rd(2'd1, v); chk("R3", "cycle count", v, 32'd10);

        // R10: wrap and write-wins
        wr(2'd1, 32'hFFFF_FFFE);
        for (int i = 0; i < 3; i++) step();
        rd(2'd1, v); chk("R10", "wrap", v, 32'd1);
        wr(2'd1, 32'd5);
        rd(2'd1, v); chk("R10", "load beats inc", v, 32'd5);

        // R2: unsupported codes with all inputs high
        under_rd = 1; under_wr = 1; r_wait = 1; b_wait = 1; clk_on = 1;
        full = '1; hs = '1; rd_out = 3; wr_out = 3;
        wr(2'd0, 20);
        for (int i = 0; i < 6; i++) step();
        wr(2'd0, 63);
        for (int i = 0; i < 6; i++) step();
        rd(2'd1, v); chk("R2", "unsupported hold", v, m_cnt);
        wr(2'd2, 3);
        rd(2'd3, v); chk("R2", "bin3 untouched", v, 32'd0);

        // R7: length qualifier
        quiet(); wr(2'd1, 0); wr(2'd0, 32);
        hs = 5'b01000; ar_len = 8'd2; step(); step();
        rd(2'd1, v); chk("R7", "AR nonzero length", v, 32'd0);
        ar_len = 0; step(); step(); step();
        rd(2'd1, v); chk("R7", "AR zero length", v, 32'd3);

        // R11: selector field truncation (0x41 -> 1)
        quiet(); wr(2'd0, 32'h41);
        rd(2'd0, v); chk("R11", "sel low bits", v, 32'd1);
        wr(2'd2, 32'h23);
        rd(2'd2, v); chk("R11", "bin low bits", v, 32'd3);

        // R8: clamp of large counts into bin 15
        wr(2'd0, 16); rd_out = 8'd200;
        for (int i = 0; i < 5; i++) step();
        wr(2'd0, 0); wr(2'd2, 15);
        rd(2'd3, v); chk("R8", "clamp to bin15", v, m_hist[15]);
        chk("R8", "clamp expected 6", m_hist[15], 32'd6);

        // R9: bin write collides with increment on same bin
        wr(2'd2, 3); wr(2'd0, 17); wr_out = 3;
        step();
        wr(2'd3, 32'd100);
        wr(2'd0, 0);
        rd(2'd3, v); chk("R9", "write beats inc", v, 32'd101);

        // seeded random walk over all codes
        foreach (codes[k]) begin
            quiet(); wr(2'd0, 32'(codes[k]));
            for (int i = 0; i < 60; i++) begin
                rnd();
                if ($urandom_range(0, 19) == 0) begin
                    if ($urandom_range(0, 1) == 0) wr(2'd1, $urandom);
                    else wr(2'd3, $urandom);
                end else step();
            end
            check_all(req_of(codes[k]));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule